// File: doc/BRIEF.md
# Double-Buffered DMA Channel Arbiter

This block sits between several DMA channels and one shared data path. Every channel owns a small FIFO made of two burst-sized buffers used in ping-pong fashion. A fill port takes words from the producing side. A drain port streams whole bursts to the consuming side. Two grants are decided independently. The fill grant goes to the highest-ranked active channel that still has a free buffer. The drain grant goes to the highest-ranked active channel whose next buffer holds a complete burst.

Because fill and drain are separate, one channel can drain while the next-ranked channel fills. Under fixed ranking, the two highest-ranked busy channels therefore take turns. When the top channel runs dry, the pair slides down one place. A mode input switches to pseudo round-robin: each channel that completes a drain burst falls to the bottom of the ranking, and the other channels keep their relative order. The block carries no direction of its own. The same instance serves either transfer direction by wiring the producer to the fill port and the consumer to the drain port.

Top module: `dbuf_dma_arb`

## Requirements
- R1: Fill and drain grants are one-hot or zero, come from registers, and stay unchanged for the whole burst. `wr_ready_o` is high only while the granted channel is active. `rd_valid_o` is high only while the granted channel is active.
- R2: When no fill grant is held, the next cycle grants the highest-ranked active channel whose current fill buffer is not full. If no channel qualifies, no grant is given.
- R3: A buffer becomes full on the 8th accepted fill word. The fill side then moves to the channel's other buffer. A channel with both buffers full receives no fill grant.
- R4: When no drain grant is held, the next cycle grants the highest-ranked active channel whose current drain buffer is full. A buffer that holds fewer than 8 words is never drained.
- R5: Drained words leave in the same order in which they were written into that channel's buffer. Each drained burst empties its buffer.
- R6: With `mode_rr_i`=0 the ranking is channel index 0 highest, then 1, 2, 3. Busy channels therefore take turns in adjacent pairs.
- R7: With `mode_rr_i`=1, the channel that completes a drain burst moves to the lowest rank at the clock edge of its final beat. The other channels keep their order. The stored ranking changes only in this mode.
- R8: A channel whose bit in `ch_active_i` is 0 gets no new grant, loses any grant it holds at the next edge, and has both buffers emptied and both pointers reset to buffer 0.
- R9: Reset sets the ranking to 0, 1, 2, 3, empties every buffer, and clears both grants. While reset is held, `wr_ready_o`, `rd_valid_o` and `rd_last_o` are 0.
- R10: `rd_last_o` is high on the 8th beat of a drain burst. The drain grant is released at the edge of that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_rr_i | input | 1 | 0 fixed ranking, 1 pseudo round-robin |
| ch_active_i | input | NUM_CH | Per-channel enable; 0 flushes the channel |
| wr_valid_i | input | 1 | Fill word present |
| wr_data_i | input | DATA_W | Fill word |
| wr_ready_o | output | 1 | Fill word accepted this cycle when valid |
| wr_grant_o | output | NUM_CH | One-hot channel currently being filled |
| rd_ready_i | input | 1 | Consumer accepts the drain word |
| rd_valid_o | output | 1 | Drain word present |
| rd_data_o | output | DATA_W | Drain word |
| rd_last_o | output | 1 | Final beat of the drain burst |
| rd_grant_o | output | NUM_CH | One-hot channel currently being drained |

## Verification
The bench builds the block with its default values: four channels, 8-word bursts and 32-bit words. With these values 16 fill words saturate one channel. This quickly reaches the state where both buffers of the top channels are full and fill overflows to lower-ranked channels. Four channels are also enough to watch the turn-taking pair slide down the ranking, and to watch round-robin rotation wrap through every position. A cycle-level reference model in the bench predicts both grants and every drained word. It does so under random handshakes, mode flips and channel shutdowns.

// File: rtl/dbuf_arb_pkg.sv
package dbuf_arb_pkg;
  typedef enum logic {
    ARB_FIXED  = 1'b0,
    ARB_ROTATE = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dbuf_arb_pick.sv
module dbuf_arb_pick #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0][IDX_W-1:0] order_i,
  input  logic [NUM_CH-1:0]            elig_i,
  output logic [NUM_CH-1:0]            gnt_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic hit;

  // scan lowest rank first so the highest eligible rank wins
  always_comb begin
    hit   = 1'b0;
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig_i[order_i[i]]) begin
        hit   = 1'b1;
        idx_o = order_i[i];
      end
    end
    gnt_o = hit ? (NUM_CH'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/dbuf_arb_order.sv
module dbuf_arb_order #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rotate_i,
  input  logic [IDX_W-1:0]             done_idx_i,
  output logic [NUM_CH-1:0][IDX_W-1:0] order_o
);
  logic [NUM_CH-1:0][IDX_W-1:0] order_q, order_d;
  int unsigned pos;

  always_comb begin
    pos = 0;
    for (int unsigned i = 0; i < NUM_CH; i++) begin
      if (order_q[i] == done_idx_i) pos = i;
    end
    for (int unsigned i = 0; i < NUM_CH - 1; i++) begin
      order_d[i] = (i < pos) ? order_q[i] : order_q[i+1];
    end
    order_d[NUM_CH-1] = done_idx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < NUM_CH; i++) order_q[i] <= IDX_W'(i);
    end else if (rotate_i) begin
      order_q <= order_d;
    end
  end

  assign order_o = order_q;
endmodule

// File: rtl/dbuf_arb_store.sv
module dbuf_arb_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dbuf_dma_arb.sv
module dbuf_dma_arb
  import dbuf_arb_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned BURST_WORDS = 8,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_rr_i,
  input  logic [NUM_CH-1:0] ch_active_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic [NUM_CH-1:0] wr_grant_o,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic [NUM_CH-1:0] rd_grant_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_CH);
  localparam int unsigned CNT_W  = $clog2(BURST_WORDS);
  localparam int unsigned ADDR_W = IDX_W + 1 + CNT_W;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_WORDS - 1);

  arb_mode_e mode;
  logic [NUM_CH-1:0][1:0]       full_q;
  logic [NUM_CH-1:0]            wbuf_q, rbuf_q;
  logic [NUM_CH-1:0]            wr_gnt_q, rd_gnt_q;
  logic [IDX_W-1:0]             wr_idx_q, rd_idx_q;
  logic [CNT_W-1:0]             wr_cnt_q, rd_cnt_q;
  logic [NUM_CH-1:0][IDX_W-1:0] rot_order, fix_order, eff_order;
  logic [NUM_CH-1:0]            wr_elig, rd_elig, wr_pick, rd_pick;
  logic [IDX_W-1:0]             wr_pick_idx, rd_pick_idx;
  logic                         wr_fire, wr_done, rd_fire, rd_done;

  assign mode = arb_mode_e'(mode_rr_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign fix_order[g] = IDX_W'(g);
    assign wr_elig[g]   = ch_active_i[g] & ~full_q[g][wbuf_q[g]];
    assign rd_elig[g]   = ch_active_i[g] &  full_q[g][rbuf_q[g]];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q[g] <= '0;
        wbuf_q[g] <= 1'b0;
        rbuf_q[g] <= 1'b0;
      end else if (!ch_active_i[g]) begin
        full_q[g] <= '0;
        wbuf_q[g] <= 1'b0;
        rbuf_q[g] <= 1'b0;
      end else begin
        // set and clear always hit different buffers of the pair
        if (wr_done && wr_idx_q == IDX_W'(g)) begin
          full_q[g][wbuf_q[g]] <= 1'b1;
          wbuf_q[g]            <= ~wbuf_q[g];
        end
        if (rd_done && rd_idx_q == IDX_W'(g)) begin
          full_q[g][rbuf_q[g]] <= 1'b0;
          rbuf_q[g]            <= ~rbuf_q[g];
        end
      end
    end
  end

  assign eff_order = (mode == ARB_ROTATE) ? rot_order : fix_order;

  dbuf_arb_order #(.NUM_CH(NUM_CH)) i_order (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rotate_i   (rd_done && mode == ARB_ROTATE),
    .done_idx_i (rd_idx_q),
    .order_o    (rot_order)
  );

  dbuf_arb_pick #(.NUM_CH(NUM_CH)) i_wr_pick (
    .order_i (eff_order),
    .elig_i  (wr_elig),
    .gnt_o   (wr_pick),
    .idx_o   (wr_pick_idx)
  );

  dbuf_arb_pick #(.NUM_CH(NUM_CH)) i_rd_pick (
    .order_i (eff_order),
    .elig_i  (rd_elig),
    .gnt_o   (rd_pick),
    .idx_o   (rd_pick_idx)
  );

  assign wr_ready_o = |(wr_gnt_q & ch_active_i);
  assign rd_valid_o = |(rd_gnt_q & ch_active_i);
  assign wr_fire    = wr_valid_i & wr_ready_o;
  assign rd_fire    = rd_ready_i & rd_valid_o;
  assign wr_done    = wr_fire & (wr_cnt_q == LAST_BEAT);
  assign rd_done    = rd_fire & (rd_cnt_q == LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_gnt_q <= '0;
      wr_idx_q <= '0;
      wr_cnt_q <= '0;
    end else if (wr_gnt_q == '0) begin
      wr_gnt_q <= wr_pick;
      wr_idx_q <= wr_pick_idx;
      wr_cnt_q <= '0;
    end else if (!ch_active_i[wr_idx_q] || wr_done) begin
      wr_gnt_q <= '0;
      wr_cnt_q <= '0;
    end else if (wr_fire) begin
      wr_cnt_q <= wr_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_gnt_q <= '0;
      rd_idx_q <= '0;
      rd_cnt_q <= '0;
    end else if (rd_gnt_q == '0) begin
      rd_gnt_q <= rd_pick;
      rd_idx_q <= rd_pick_idx;
      rd_cnt_q <= '0;
    end else if (!ch_active_i[rd_idx_q] || rd_done) begin
      rd_gnt_q <= '0;
      rd_cnt_q <= '0;
    end else if (rd_fire) begin
      rd_cnt_q <= rd_cnt_q + 1'b1;
    end
  end

  dbuf_arb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .waddr_i ({wr_idx_q, wbuf_q[wr_idx_q], wr_cnt_q}),
    .wdata_i (wr_data_i),
    .raddr_i ({rd_idx_q, rbuf_q[rd_idx_q], rd_cnt_q}),
    .rdata_o (rd_data_o)
  );

  assign wr_grant_o = wr_gnt_q;
  assign rd_grant_o = rd_gnt_q;
  assign rd_last_o  = rd_valid_o & (rd_cnt_q == LAST_BEAT);
endmodule

module dbuf_dma_arb_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] ch_active_i,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic [NUM_CH-1:0] wr_grant_o,
  input logic              rd_ready_i,
  input logic              rd_valid_o,
  input logic              rd_last_o,
  input logic [NUM_CH-1:0] rd_grant_o
);
  // R1
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_grant_o));
  // R1
  rd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_grant_o));
  // R1
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ready_o && !wr_valid_i) |=> $stable(wr_grant_o));
  // R1
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> $stable(rd_grant_o));
  // R10
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ready_i && rd_last_o) |=> (rd_grant_o == '0));
  // R8
  wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_active_i != '1) |=> ((wr_grant_o & ~$past(ch_active_i)) == '0));
  // R8
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_active_i != '1) |=> ((rd_grant_o & ~$past(ch_active_i)) == '0));
endmodule

bind dbuf_dma_arb dbuf_dma_arb_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ch_active_i (ch_active_i),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .wr_grant_o  (wr_grant_o),
  .rd_ready_i  (rd_ready_i),
  .rd_valid_o  (rd_valid_o),
  .rd_last_o   (rd_last_o),
  .rd_grant_o  (rd_grant_o)
);

// File: tb/test_dbuf_dma_arb.sv
`timescale 1ns/1ps
module test_dbuf_dma_arb;
  localparam int NCH = 4;
  localparam int BW  = 8;
  localparam int DW  = 32;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           mode_rr_i = 1'b0;
  logic [NCH-1:0] ch_active_i = '0;
  logic           wr_valid_i = 1'b0;
  logic [DW-1:0]  wr_data_i = '0;
  logic           rd_ready_i = 1'b0;
  logic           wr_ready_o, rd_valid_o, rd_last_o;
  logic [NCH-1:0] wr_grant_o, rd_grant_o;
  logic [DW-1:0]  rd_data_o;

  dbuf_dma_arb #(.NUM_CH(NCH), .BURST_WORDS(BW), .DATA_W(DW)) i_dbuf_dma_arb (
    .clk_i, .rst_ni, .mode_rr_i, .ch_active_i, .wr_valid_i, .wr_data_i,
    .wr_ready_o, .wr_grant_o, .rd_ready_i, .rd_valid_o, .rd_data_o,
    .rd_last_o, .rd_grant_o
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  bit            mfull [NCH][2];
  bit            mwb [NCH];
  bit            mrb [NCH];
  int            mord [NCH];
  int            mwg, mrg, mwc, mrc;
  logic [DW-1:0] mmem [NCH][2][BW];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] oh(int i);
    return (i < 0) ? '0 : NCH'(1) << i;
  endfunction

  function automatic int pick(bit elig[NCH], int ord[NCH]);
    for (int i = 0; i < NCH; i++) if (elig[ord[i]]) return ord[i];
    return -1;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      mfull[c][0] = 0; mfull[c][1] = 0; mwb[c] = 0; mrb[c] = 0; mord[c] = c;
    end
    mwg = -1; mrg = -1; mwc = 0; mrc = 0;
  endtask

  task automatic compare(string ptag);
    bit ew = (mwg >= 0) && ch_active_i[mwg];
    bit er = (mrg >= 0) && ch_active_i[mrg];
    chk({ptag, " R2"}, "wr_grant", wr_grant_o, oh(mwg));
    chk({ptag, " R4"}, "rd_grant", rd_grant_o, oh(mrg));
    chk("R1", "wr_ready", wr_ready_o, ew);
    chk("R1", "rd_valid", rd_valid_o, er);
    chk("R10", "rd_last", rd_last_o, er && (mrc == BW - 1));
    if (er) chk("R5", "rd_data", rd_data_o, mmem[mrg][mrb[mrg]][mrc]);
  endtask

  task automatic step_model();
    bit welig[NCH];
    bit relig[NCH];
    int eo[NCH];
    int pw, pr, d, p;
    bit wa = (mwg >= 0) && ch_active_i[mwg] && wr_valid_i;
    bit ra = (mrg >= 0) && ch_active_i[mrg] && rd_ready_i;
    for (int c = 0; c < NCH; c++) begin
      welig[c] = ch_active_i[c] && !mfull[c][mwb[c]];
      relig[c] = ch_active_i[c] &&  mfull[c][mrb[c]];
      eo[c]    = mode_rr_i ? mord[c] : c;
    end
    pw = pick(welig, eo);
    pr = pick(relig, eo);
    if (mwg < 0) begin
      mwg = pw; mwc = 0;
    end else if (!ch_active_i[mwg]) begin
      mwg = -1; mwc = 0;
    end else if (wa) begin
      mmem[mwg][mwb[mwg]][mwc] = wr_data_i;
      if (mwc == BW - 1) begin
        mfull[mwg][mwb[mwg]] = 1; mwb[mwg] = !mwb[mwg]; mwg = -1; mwc = 0;
      end else mwc++;
    end
    if (mrg < 0) begin
      mrg = pr; mrc = 0;
    end else if (!ch_active_i[mrg]) begin
      mrg = -1; mrc = 0;
    end else if (ra) begin
      if (mrc == BW - 1) begin
        d = mrg;
        mfull[d][mrb[d]] = 0; mrb[d] = !mrb[d]; mrg = -1; mrc = 0;
        if (mode_rr_i) begin
          p = 0;
          for (int i = 0; i < NCH; i++) if (mord[i] == d) p = i;
          for (int i = p; i < NCH - 1; i++) mord[i] = mord[i+1];
          mord[NCH-1] = d;
        end
      end else mrc++;
    end
    for (int c = 0; c < NCH; c++) begin
      if (!ch_active_i[c]) begin
        mfull[c][0] = 0; mfull[c][1] = 0; mwb[c] = 0; mrb[c] = 0;
      end
    end
  endtask

  task automatic cycle(string ptag, bit md, logic [NCH-1:0] act, bit wv, bit rr);
    @(negedge clk_i);
    mode_rr_i   = md;
    ch_active_i = act;
    wr_valid_i  = wv;
    wr_data_i   = $urandom;
    rd_ready_i  = rr;
    #1;
    compare(ptag);
    step_model();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed = $urandom(32'd4711);
    model_reset();
    repeat (3) @(negedge clk_i);
    // R9: outputs quiet during reset
    chk("R9", "wr_ready in reset", wr_ready_o, 0);
    chk("R9", "rd_valid in reset", rd_valid_o, 0);
    chk("R9", "rd_last in reset", rd_last_o, 0);
    chk("R9", "grants in reset", {wr_grant_o, rd_grant_o}, 0);
    rst_ni = 1'b1;
    cycle("R9", 0, '1, 0, 0);

    // R3: no draining; channels 0 and 1 saturate, then fill stops
    for (int i = 0; i < 50; i++) cycle("R3", 0, 4'b0011, 1, 0);
    chk("R3", "fill stops when both buffers full", wr_ready_o, 0);

    // R6: fixed ranking, all channels busy, free-running handshakes
    for (int i = 0; i < 800; i++) cycle("R6", 0, '1, 1, 1);
    for (int i = 0; i < 3000; i++) cycle("R6", 0, '1, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);

    // R7: rotating ranking
    for (int i = 0; i < 4000; i++) cycle("R7", 1, '1, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);

    // R8: channel shutdowns mixed with mode flips
    begin
      logic [NCH-1:0] act = '1;
      bit md = 0;
      for (int i = 0; i < 12000; i++) begin
        if ($urandom_range(0, 99) == 0) act[$urandom_range(0, NCH - 1)] ^= 1'b1;
        if ($urandom_range(0, 499) == 0) md = !md;
        cycle("R8", md, act, $urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0);
      end
    end

    // R8: single channel alive, others flushed
    for (int i = 0; i < 200; i++) cycle("R8", 1, 4'b0100, 1, $urandom_range(0, 1) == 1);
    for (int i = 0; i < 200; i++) cycle("R7", 1, '1, 1, 1);

    finish_run();
  end
endmodule